// File: doc/BRIEF.md
# CDR Control and Status Register Bank

This block holds the software-visible control and status state of a clock-and-data-recovery receiver. A synchronous register port (write enable, read enable, address, byte data) gives access to the frequency readback bytes, the coarse rate, a status byte and three control bytes. The control bytes drive the reference band, divider ratio code, measurement start and lock source of the recovery core. A few control bits act as one-shot commands: they fire when software writes a 1 and then a 0.

The block also shapes three kinds of output from the live status of the core. The external loss-of-lock pin either follows the live lock state or latches a lock loss until software clears it. The loss-of-signal pin has a programmable polarity. The recovered clock and data are squelched while the signal is lost, either both together or one of them chosen by the `squelch_sel` input.

Top module: `cdr_csr`

## Requirements
- R1: After reset every control register (0x08, 0x09, 0x11) reads 0x00, and `ref_band`, `ratio_code`, `meas_start`, `lock_to_ref` and `sys_rst_pulse` are all 0.
- R2: Register 0x08 stores all 8 bits and drives its fields: bits 7:6 give `ref_band`, bits 5:2 give `ratio_code`, bit 1 gives `meas_start` and bit 0 gives `lock_to_ref`. A read returns its data on `rdata` one clock after `rd_en`, and `rdata` holds its value while `rd_en` is low.
- R3: Register 0x09 keeps only bits 7, 6, 5 and 3, and register 0x11 keeps only bits 2 and 1. The other bits of both registers read as 0.
- R4: Addresses 0x00, 0x01 and 0x02 return frequency bits 7:0, 15:8 and 23:16. Address 0x03 returns rate bits 8:1. Address 0x04 returns the status byte: bit 5 is live loss of signal, bit 4 is sticky loss of lock, bit 3 is live loss of lock, bit 2 is measurement complete, bit 0 is rate bit 0, and all other bits are 0.
- R5: Status bit 4 sets on any clock in which `lol_in` is high and stays set after `lol_in` falls.
- R6: Status bit 4 clears only when a write to 0x09 takes bit 6 from 1 to 0. Writing a 0 over a 0 has no effect, and neither does writing a 1.
- R7: If a clear of status bit 4 and a high `lol_in` fall in the same clock, bit 4 stays set.
- R8: Status bit 2 sets on a clock in which `meas_done_in` is high, and holds. A write to 0x09 that takes bit 3 from 1 to 0 clears it.
- R9: A write to 0x09 that takes bit 5 from 1 to 0 sets registers 0x08, 0x09 and 0x11 and both sticky status bits to 0 at that edge. `sys_rst_pulse` is high for exactly the following clock.
- R10: When 0x09 bit 7 is 0, `lol_pin` equals `lol_in`. When bit 7 is 1, `lol_pin` is the OR of `lol_in` and status bit 4.
- R11: `los_pin` equals `los_in` when 0x11 bit 2 is 0, and equals its inverse when that bit is 1.
- R12: While `los_in` is low, neither squelch output is active. While `los_in` is high and 0x11 bit 1 is 0, both are active. While `los_in` is high and bit 1 is 1, `clk_squelch` is active when `squelch_sel` is 0 and `data_squelch` is active when `squelch_sel` is 1.
- R13: Reads of addresses outside 0x00–0x04, 0x08, 0x09 and 0x11 return 0x00. Writes to those addresses or to 0x00–0x04 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| los_in | input | 1 | Live loss of signal from the core |
| lol_in | input | 1 | Live loss of lock from the core (1 = acquiring) |
| meas_done_in | input | 1 | Rate measurement finished |
| rate_in | input | 9 | Coarse rate value |
| freq_in | input | FREQ_W | Frequency readback value |
| squelch_sel | input | 1 | In split squelch mode, picks data (1) or clock (0) |
| ref_band | output | 2 | Reference range band |
| ratio_code | output | 4 | Divider ratio code n (ratio 2^n) |
| meas_start | output | 1 | Start rate measurement |
| lock_to_ref | output | 1 | 1 = lock to reference, 0 = lock to data |
| sys_rst_pulse | output | 1 | One-clock system reset command |
| lol_pin | output | 1 | External loss-of-lock indication |
| los_pin | output | 1 | External loss-of-signal indication |
| clk_squelch | output | 1 | Force recovered clock low |
| data_squelch | output | 1 | Force recovered data low |

## Verification
The bench goes after the write-1-then-0 command protocol. It checks that a bare 0 or a bare 1 fires nothing, because a design that detected the level or the rising edge would clear the status by accident. It drives a clear and a new lock loss into the same clock; a design that gave the clear priority would lose that lock loss. It checks that the system reset also wipes register 0x09 and that its pulse lasts one clock, which catches a pulse that repeats or a bank that keeps the written data. It checks the latched pin mode with the live lock already restored, and both split squelch selections, which expose a pin that follows only the live state and swapped squelch outputs.

// File: rtl/cdr_csr_pkg.sv
package cdr_csr_pkg;
  localparam int DW     = 8;
  localparam int RATE_W = 9;

  // register addresses
  localparam int A_RATE = 'h03;
  localparam int A_STAT = 'h04;
  localparam int A_CTLA = 'h08;
  localparam int A_CTLB = 'h09;
  localparam int A_CTLC = 'h11;

  // command / mode bit positions in 0x09 and 0x11
  localparam int B_LOLMODE = 7;
  localparam int B_CLRLOL  = 6;
  localparam int B_SYSRST  = 5;
  localparam int B_CLRMEAS = 3;
  localparam int C_LOSINV  = 2;
  localparam int C_SQSPLIT = 1;

  typedef struct packed {
    logic [1:0] band;
    logic [3:0] ratio;
    logic       meas;
    logic       lock_ref;
  } ctla_t;

  typedef struct packed {
    logic lol_static;
    logic clr_lol;
    logic sys_rst;
    logic clr_meas;
  } ctlb_t;

  typedef struct packed {
    logic los_inv;
    logic sq_split;
  } ctlc_t;
endpackage

// File: rtl/cdr_csr_ctrl.sv
module cdr_csr_ctrl
  import cdr_csr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output ctla_t             ctla,
  output ctlb_t             ctlb,
  output ctlc_t             ctlc,
  output logic              clr_lol_p,
  output logic              clr_meas_p,
  output logic              sys_rst_p,
  output logic              sys_rst_q
);
  ctla_t ctla_q, ctla_d;
  ctlb_t ctlb_q, ctlb_d;
  ctlc_t ctlc_q, ctlc_d;
  logic  hit_a, hit_b, hit_c;
  logic  en_a, en_b, en_c;

  assign hit_a = wr_en && (addr == ADDR_W'(A_CTLA));
  assign hit_b = wr_en && (addr == ADDR_W'(A_CTLB));
  assign hit_c = wr_en && (addr == ADDR_W'(A_CTLC));

  // one-shot commands: stored 1 overwritten by 0
  assign clr_lol_p  = hit_b && ctlb_q.clr_lol  && !wdata[B_CLRLOL];
  assign clr_meas_p = hit_b && ctlb_q.clr_meas && !wdata[B_CLRMEAS];
  assign sys_rst_p  = hit_b && ctlb_q.sys_rst  && !wdata[B_SYSRST];

  assign en_a = hit_a || sys_rst_p;
  assign en_b = hit_b;
  assign en_c = hit_c || sys_rst_p;

  always_comb begin
    ctla_d = ctla_q;
    ctlb_d = ctlb_q;
    ctlc_d = ctlc_q;
    if (hit_a) ctla_d = ctla_t'(wdata);
    if (hit_b) ctlb_d = '{lol_static: wdata[B_LOLMODE], clr_lol: wdata[B_CLRLOL],
                          sys_rst: wdata[B_SYSRST], clr_meas: wdata[B_CLRMEAS]};
    if (hit_c) ctlc_d = '{los_inv: wdata[C_LOSINV], sq_split: wdata[C_SQSPLIT]};
    if (sys_rst_p) begin
      ctla_d = '0;
      ctlb_d = '0;
      ctlc_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctla_q    <= '0;
      ctlb_q    <= '0;
      ctlc_q    <= '0;
      sys_rst_q <= 1'b0;
    end else begin
      if (en_a) ctla_q <= ctla_d;
      if (en_b) ctlb_q <= ctlb_d;
      if (en_c) ctlc_q <= ctlc_d;
      sys_rst_q <= sys_rst_p;
    end
  end

  assign ctla = ctla_q;
  assign ctlb = ctlb_q;
  assign ctlc = ctlc_q;
endmodule

// File: rtl/cdr_csr_status.sv
module cdr_csr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic lol_in,
  input  logic meas_done_in,
  input  logic clr_lol_p,
  input  logic clr_meas_p,
  input  logic sys_rst_p,
  output logic lol_sticky,
  output logic meas_cpl
);
  logic lol_q, lol_d, meas_q, meas_d;

  // a new event always wins over a clear in the same clock
  always_comb begin
    lol_d  = lol_q;
    meas_d = meas_q;
    if (clr_lol_p || sys_rst_p)  lol_d  = 1'b0;
    if (clr_meas_p || sys_rst_p) meas_d = 1'b0;
    if (lol_in)       lol_d  = 1'b1;
    if (meas_done_in) meas_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lol_q  <= 1'b0;
      meas_q <= 1'b0;
    end else begin
      lol_q  <= lol_d;
      meas_q <= meas_d;
    end
  end

  assign lol_sticky = lol_q;
  assign meas_cpl   = meas_q;
endmodule

// File: rtl/cdr_csr_pins.sv
module cdr_csr_pins (
  input  logic los_in,
  input  logic lol_in,
  input  logic lol_sticky,
  input  logic lol_static,
  input  logic los_inv,
  input  logic sq_split,
  input  logic squelch_sel,
  output logic lol_pin,
  output logic los_pin,
  output logic clk_squelch,
  output logic data_squelch
);
  always_comb begin
    lol_pin = lol_static ? (lol_in | lol_sticky) : lol_in;
    los_pin = los_in ^ los_inv;
    clk_squelch  = 1'b0;
    data_squelch = 1'b0;
    if (los_in) begin
      if (sq_split) begin
        clk_squelch  = !squelch_sel;
        data_squelch = squelch_sel;
      end else begin
        clk_squelch  = 1'b1;
        data_squelch = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cdr_csr.sv
module cdr_csr
  import cdr_csr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int FREQ_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              los_in,
  input  logic              lol_in,
  input  logic              meas_done_in,
  input  logic [RATE_W-1:0] rate_in,
  input  logic [FREQ_W-1:0] freq_in,
  input  logic              squelch_sel,
  output logic [1:0]        ref_band,
  output logic [3:0]        ratio_code,
  output logic              meas_start,
  output logic              lock_to_ref,
  output logic              sys_rst_pulse,
  output logic              lol_pin,
  output logic              los_pin,
  output logic              clk_squelch,
  output logic              data_squelch
);
  localparam int FREQ_BYTES = FREQ_W / DW;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  ctla_t ctla;
  ctlb_t ctlb;
  ctlc_t ctlc;
  logic  clr_lol_p, clr_meas_p, sys_rst_p;
  logic  lol_sticky, meas_cpl;

  cdr_csr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctla(ctla), .ctlb(ctlb), .ctlc(ctlc),
    .clr_lol_p(clr_lol_p), .clr_meas_p(clr_meas_p), .sys_rst_p(sys_rst_p),
    .sys_rst_q(sys_rst_pulse)
  );

  cdr_csr_status u_stat (
    .clk(clk), .rst_n(rst_sn), .lol_in(lol_in), .meas_done_in(meas_done_in),
    .clr_lol_p(clr_lol_p), .clr_meas_p(clr_meas_p), .sys_rst_p(sys_rst_p),
    .lol_sticky(lol_sticky), .meas_cpl(meas_cpl)
  );

  cdr_csr_pins u_pins (
    .los_in(los_in), .lol_in(lol_in), .lol_sticky(lol_sticky),
    .lol_static(ctlb.lol_static), .los_inv(ctlc.los_inv), .sq_split(ctlc.sq_split),
    .squelch_sel(squelch_sel), .lol_pin(lol_pin), .los_pin(los_pin),
    .clk_squelch(clk_squelch), .data_squelch(data_squelch)
  );

  assign ref_band    = ctla.band;
  assign ratio_code  = ctla.ratio;
  assign meas_start  = ctla.meas;
  assign lock_to_ref = ctla.lock_ref;

  // read path
  logic [DW-1:0] freq_byte [FREQ_BYTES];
  for (genvar g = 0; g < FREQ_BYTES; g++) begin : g_fbyte
    assign freq_byte[g] = freq_in[g*DW +: DW];
  end

  logic [DW-1:0] rd_mux, rdata_q;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < FREQ_BYTES; i++)
      if (addr == ADDR_W'(i)) rd_mux = freq_byte[i];
    if (addr == ADDR_W'(A_RATE)) rd_mux = rate_in[RATE_W-1:1];
    if (addr == ADDR_W'(A_STAT))
      rd_mux = {2'b00, los_in, lol_sticky, lol_in, meas_cpl, 1'b0, rate_in[0]};
    if (addr == ADDR_W'(A_CTLA)) rd_mux = ctla;
    if (addr == ADDR_W'(A_CTLB))
      rd_mux = {ctlb.lol_static, ctlb.clr_lol, ctlb.sys_rst, 1'b0, ctlb.clr_meas, 3'b000};
    if (addr == ADDR_W'(A_CTLC))
      rd_mux = {5'b00000, ctlc.los_inv, ctlc.sq_split, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end
  assign rdata = rdata_q;
endmodule

// File: rtl/cdr_csr_chk.sv
module cdr_csr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lol_in,
  input logic       los_in,
  input logic       lol_sticky,
  input logic       clr_lol_p,
  input logic       sys_rst_p,
  input logic       sys_rst_pulse,
  input logic       lol_static,
  input logic       sq_split,
  input logic       lol_pin,
  input logic       clk_squelch,
  input logic       data_squelch,
  input logic [1:0] ref_band,
  input logic [3:0] ratio_code,
  input logic       meas_start,
  input logic       lock_to_ref
);
  a_r5_sticky_sets: assert property (@(posedge clk) disable iff (!rst_n)
    lol_in |=> lol_sticky);
  a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lol_sticky && !clr_lol_p && !sys_rst_p) |=> lol_sticky);
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (lol_in && clr_lol_p) |=> lol_sticky);
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |=> !sys_rst_pulse);
  a_r9_fields_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> (ref_band == 2'b00 && ratio_code == 4'h0 && !meas_start && !lock_to_ref
                       && !lol_sticky));
  a_r10_static_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (lol_static && lol_sticky) |-> lol_pin);
  a_r10_normal_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !lol_static |-> (lol_pin == lol_in));
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !los_in |-> (!clk_squelch && !data_squelch));
  a_r12_split_one: assert property (@(posedge clk) disable iff (!rst_n)
    (los_in && sq_split) |-> $countones({clk_squelch, data_squelch}) == 1);
endmodule

bind cdr_csr cdr_csr_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .lol_in(lol_in), .los_in(los_in),
  .lol_sticky(lol_sticky), .clr_lol_p(clr_lol_p), .sys_rst_p(sys_rst_p),
  .sys_rst_pulse(sys_rst_pulse), .lol_static(ctlb.lol_static), .sq_split(ctlc.sq_split),
  .lol_pin(lol_pin), .clk_squelch(clk_squelch), .data_squelch(data_squelch),
  .ref_band(ref_band), .ratio_code(ratio_code), .meas_start(meas_start),
  .lock_to_ref(lock_to_ref)
);

// File: tb/tb_cdr_csr.sv
`timescale 1ns/1ps
module tb_cdr_csr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       los_in = 1'b0, lol_in = 1'b0, meas_done_in = 1'b0, squelch_sel = 1'b0;
  logic [8:0] rate_in = '0;
  logic [23:0] freq_in = '0;
  logic [1:0] ref_band;
  logic [3:0] ratio_code;
  logic meas_start, lock_to_ref, sys_rst_pulse, lol_pin, los_pin, clk_squelch, data_squelch;

  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  cdr_csr dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .los_in(los_in), .lol_in(lol_in), .meas_done_in(meas_done_in),
    .rate_in(rate_in), .freq_in(freq_in), .squelch_sel(squelch_sel),
    .ref_band(ref_band), .ratio_code(ratio_code), .meas_start(meas_start),
    .lock_to_ref(lock_to_ref), .sys_rst_pulse(sys_rst_pulse), .lol_pin(lol_pin),
    .los_pin(los_pin), .clk_squelch(clk_squelch), .data_squelch(data_squelch)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic lol_blip();
    @(negedge clk); lol_in = 1'b1;
    @(negedge clk); lol_in = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(5'h08, v); chk("R1 ctla", v, 8'h00);
    rd(5'h09, v); chk("R1 ctlb", v, 8'h00);
    rd(5'h11, v); chk("R1 ctlc", v, 8'h00);
    chk("R1 outputs", {ref_band, ratio_code, meas_start, lock_to_ref, sys_rst_pulse}, 0);
  endtask

  task automatic t_ctla();
    logic [7:0] v;
    wr(5'h08, 8'hAB);
    chk("R2 fields", {ref_band, ratio_code, meas_start, lock_to_ref}, {2'd2, 4'hA, 1'b1, 1'b1});
    rd(5'h08, v); chk("R2 readback", v, 8'hAB);
    @(negedge clk); addr = 5'h11; @(negedge clk);
    chk("R2 rdata holds", rdata, 8'hAB);
    wr(5'h08, 8'h54);
    chk("R2 fields2", {ref_band, ratio_code, meas_start, lock_to_ref}, {2'd1, 4'h5, 1'b0, 1'b0});
  endtask

  task automatic t_masks();
    logic [7:0] v;
    wr(5'h11, 8'hFF); rd(5'h11, v); chk("R3 ctlc mask", v, 8'h06);
    wr(5'h11, 8'h00);
    wr(5'h09, 8'h97); rd(5'h09, v); chk("R3 ctlb mask", v, 8'h80);
    wr(5'h09, 8'h00);
  endtask

  task automatic t_status_live();
    logic [7:0] v;
    freq_in = 24'h123456; rate_in = 9'h1A5;
    rd(5'h00, v); chk("R4 freq0", v, 8'h56);
    rd(5'h01, v); chk("R4 freq1", v, 8'h34);
    rd(5'h02, v); chk("R4 freq2", v, 8'h12);
    rd(5'h03, v); chk("R4 rate", v, 8'hD2);
    @(negedge clk); los_in = 1'b1; lol_in = 1'b1;
    rd(5'h04, v); chk("R4 status live", v, 8'h39);
    los_in = 1'b0; lol_in = 1'b0; rate_in = 9'h0;
    rd(5'h04, v); chk("R5 sticky kept", v, 8'h10);
  endtask

  task automatic t_clear_protocol();
    logic [7:0] v;
    wr(5'h09, 8'h00); rd(5'h04, v); chk("R6 zero-over-zero", v[4], 1'b1);
    wr(5'h09, 8'h40); rd(5'h04, v); chk("R6 one-write", v[4], 1'b1);
    wr(5'h09, 8'h00); rd(5'h04, v); chk("R6 one-then-zero", v[4], 1'b0);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    wr(5'h09, 8'h40);
    @(negedge clk); wr_en = 1'b1; addr = 5'h09; wdata = 8'h00; lol_in = 1'b1;
    @(negedge clk); wr_en = 1'b0; lol_in = 1'b0;
    rd(5'h04, v); chk("R7 set beats clear", v[4], 1'b1);
    wr(5'h09, 8'h40); wr(5'h09, 8'h00);
    rd(5'h04, v); chk("R7 later clear", v[4], 1'b0);
  endtask

  task automatic t_meas();
    logic [7:0] v;
    @(negedge clk); meas_done_in = 1'b1;
    @(negedge clk); meas_done_in = 1'b0;
    rd(5'h04, v); chk("R8 done set", v[2], 1'b1);
    wr(5'h09, 8'h08); rd(5'h04, v); chk("R8 held", v[2], 1'b1);
    wr(5'h09, 8'h00); rd(5'h04, v); chk("R8 cleared", v[2], 1'b0);
  endtask

  task automatic t_sysrst();
    logic [7:0] v;
    lol_blip();
    wr(5'h08, 8'hAB); wr(5'h11, 8'h06); wr(5'h09, 8'hA0);
    chk("R9 pulse idle", sys_rst_pulse, 1'b0);
    wr(5'h09, 8'h80);
    chk("R9 pulse high", sys_rst_pulse, 1'b1);
    @(negedge clk); chk("R9 pulse one clock", sys_rst_pulse, 1'b0);
    chk("R9 fields", {ref_band, ratio_code, meas_start, lock_to_ref}, 0);
    rd(5'h09, v); chk("R9 ctlb zero", v, 8'h00);
    rd(5'h11, v); chk("R9 ctlc zero", v, 8'h00);
    rd(5'h04, v); chk("R9 sticky zero", v[4], 1'b0);
  endtask

  task automatic t_lol_pin();
    @(negedge clk); lol_in = 1'b1; #1 chk("R10 normal high", lol_pin, 1'b1);
    @(negedge clk); lol_in = 1'b0; #1 chk("R10 normal follows", lol_pin, 1'b0);
    wr(5'h09, 8'h80); #1 chk("R10 static latched", lol_pin, 1'b1);
    wr(5'h09, 8'hC0); wr(5'h09, 8'h80); #1 chk("R10 static cleared", lol_pin, 1'b0);
    wr(5'h09, 8'h00);
  endtask

  task automatic t_los_squelch();
    @(negedge clk); los_in = 1'b1; #1 chk("R11 active high", los_pin, 1'b1);
    chk("R12 both", {clk_squelch, data_squelch}, 2'b11);
    wr(5'h11, 8'h06); #1 chk("R11 active low", los_pin, 1'b0);
    squelch_sel = 1'b0; #1 chk("R12 split clk", {clk_squelch, data_squelch}, 2'b10);
    squelch_sel = 1'b1; #1 chk("R12 split data", {clk_squelch, data_squelch}, 2'b01);
    @(negedge clk); los_in = 1'b0; #1 chk("R11 inverted idle", los_pin, 1'b1);
    chk("R12 none", {clk_squelch, data_squelch}, 2'b00);
    wr(5'h11, 8'h00); squelch_sel = 1'b0;
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    wr(5'h08, 8'h3C);
    rd(5'h07, v); chk("R13 read hole", v, 8'h00);
    rd(5'h1F, v); chk("R13 read top", v, 8'h00);
    wr(5'h04, 8'hFF); wr(5'h07, 8'hFF); wr(5'h19, 8'hFF); wr(5'h01, 8'hFF);
    rd(5'h04, v); chk("R13 status untouched", v, 8'h00);
    rd(5'h08, v); chk("R13 ctla untouched", v, 8'h3C);
    rd(5'h09, v); chk("R13 ctlb untouched", v, 8'h00);
    chk("R13 pins", {lol_pin, los_pin, clk_squelch, data_squelch, sys_rst_pulse}, 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctla();
    t_masks();
    t_status_live();
    t_clear_protocol();
    t_same_cycle();
    t_meas();
    t_sysrst();
    t_lol_pin();
    t_los_squelch();
    t_unimpl();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule